// File: doc/BRIEF.md
# Partial-Write General Register File

This block holds the general-purpose integer registers of an execution core: sixteen 64-bit entries behind one synchronous write port and two combinational read ports. Every access names a register and a width: the low byte, the second byte (bits 15:8), the low 16 bits, the low 32 bits or the whole register. A narrow write changes the full register in a fixed way. The 32-bit form clears the upper half. The byte and 16-bit forms leave every bit outside their lane untouched.

The second-byte alias exists only on the first four registers. The low byte works on all sixteen, including registers 4 to 7, which older eight-register designs did not reach at byte width. A request that names the second byte on any other register, or that uses an undefined width code, is flagged as illegal. An illegal write is dropped and an illegal read returns zero. Reads are combinational and return the chosen slice right-aligned and zero-extended. A read and a write to the same register in one cycle show the value from before the write.

Top module: `gpr_file`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all sixteen registers become zero, and every read returns zero afterwards until a write.
- R2: Width code 4 (full) writes all 64 bits of `wr_data` into the register, and a full read returns all 64 bits.
- R3: Width code 3 (word) stores `wr_data[31:0]` in bits 31:0 and forces bits 63:32 to zero.
- R4: Width code 2 (half) replaces bits 15:0 with `wr_data[15:0]`, and bits 63:16 keep their previous value.
- R5: Width code 0 (low byte) replaces bits 7:0 with `wr_data[7:0]` and keeps bits 63:8. It is legal on all sixteen registers, indices 4 to 7 included.
- R6: Width code 1 (second byte) on index 0 to 3 replaces bits 15:8 with `wr_data[7:0]` and keeps all other bits. A read of it returns bits 15:8 in bits 7:0 with zeros above.
- R7: Width code 1 on index 4 or higher is illegal. The write is suppressed and `wr_illegal` is high while `wr_en` is high. On a read port the matching illegal output is high and the data is zero.
- R8: Width codes 5, 6 and 7 are illegal on every index, with the same write suppression, flags and zero read data as R7.
- R9: A read returns the selected slice zero-extended to 64 bits. A read of the register being written in the same cycle returns the value from before that write.
- R10: With `wr_en` low no register changes and `wr_illegal` stays low, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 3 | Write width code (0 low byte, 1 second byte, 2 half, 3 word, 4 full) |
| wr_data | input | 64 | Write data, right-aligned |
| wr_illegal | output | 1 | Enabled write request is illegal and was dropped |
| rda_idx | input | 4 | Read port A register index |
| rda_size | input | 3 | Read port A width code |
| rda_data | output | 64 | Read port A data, zero-extended |
| rda_illegal | output | 1 | Read port A request is illegal |
| rdb_idx | input | 4 | Read port B register index |
| rdb_size | input | 3 | Read port B width code |
| rdb_data | output | 64 | Read port B data, zero-extended |
| rdb_illegal | output | 1 | Read port B request is illegal |

## Verification
The bench sweeps all sixteen indices against all eight width codes. Each register is first filled with a full-width pattern so that any bits a narrow write should keep are non-zero. A merge that zero-extended byte or 16-bit writes would lose those upper bits. A word write that kept them would leave stale data in bits 63:32. A second-byte alias decoded for every index would corrupt bits 15:8 of registers 4 to 15 instead of raising the flag. Same-cycle read-before-write, disabled writes that carry an illegal request, and a reset in the middle of a run are probed as well. The run ends with a full comparison against the bench's own model, which exposes a write that reached the wrong index.

// File: rtl/gpr_pkg.sv
// Package gpr_pkg
// Shared width codes for the partial-write register file.
// Assumes a 3-bit width field; the codes not listed here are illegal.
package gpr_pkg;

    typedef enum logic [2:0] {
        SZ_BYTE_LO = 3'd0,
        SZ_BYTE_HI = 3'd1,
        SZ_HALF    = 3'd2,
        SZ_WORD    = 3'd3,
        SZ_FULL    = 3'd4
    } gpr_size_e;

endpackage

// File: rtl/gpr_access_decode.sv
// Module gpr_access_decode
// Turns an index and width code into a lane mask plus control bits.
// The mask marks the bits the access touches in register coordinates.
// An illegal request yields an all-zero mask and legal = 0.
// Assumes XLEN is a multiple of 8 and at least 32.
module gpr_access_decode #(
    parameter int XLEN           = 64,
    parameter int NREGS          = 16,
    parameter int HI_ALIAS_NREGS = 4,
    parameter int IDX_W          = $clog2(NREGS)
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [2:0]       size,
    output logic             legal,
    output logic [XLEN-1:0]  lane_mask,
    output logic             clear_upper,
    output logic             hi_lane
);
    import gpr_pkg::*;

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int WORD_W = 32;

    localparam logic [XLEN-1:0] BYTE_MASK = {{(XLEN-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
    localparam logic [XLEN-1:0] HALF_MASK = {{(XLEN-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    localparam logic [XLEN-1:0] WORD_MASK = {{(XLEN-WORD_W){1'b0}}, {WORD_W{1'b1}}};
    localparam logic [XLEN-1:0] HI_MASK   = BYTE_MASK << BYTE_W;
    localparam logic [IDX_W:0]  HI_LIMIT  = HI_ALIAS_NREGS[IDX_W:0];

    logic hi_alias_ok;

    // Second-byte alias exists only on the lowest HI_ALIAS_NREGS indices.
    assign hi_alias_ok = ({1'b0, idx} < HI_LIMIT);

    // Width code to lane mask and merge controls.
    always_comb begin
        legal       = 1'b1;
        lane_mask   = '0;
        clear_upper = 1'b0;
        hi_lane     = 1'b0;
        case (size)
            SZ_BYTE_LO: lane_mask = BYTE_MASK;
            SZ_BYTE_HI: begin
                if (hi_alias_ok) begin
                    lane_mask = HI_MASK;
                    hi_lane   = 1'b1;
                end else begin
                    legal = 1'b0;
                end
            end
            SZ_HALF:    lane_mask = HALF_MASK;
            SZ_WORD: begin
                lane_mask   = WORD_MASK;
                clear_upper = 1'b1;
            end
            SZ_FULL:    lane_mask = '1;
            default:    legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpr_write_merge.sv
// Module gpr_write_merge
// Builds the next value of the written register from its old value.
// clear_upper zeroes every bit outside the lane.
// Otherwise the bits outside the lane are kept.
// hi_lane moves the low data byte up to the second byte lane.
module gpr_write_merge #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] wr_data,
    input  logic [XLEN-1:0] lane_mask,
    input  logic            clear_upper,
    input  logic            hi_lane,
    output logic [XLEN-1:0] new_val
);
    localparam int BYTE_W = 8;

    logic [XLEN-1:0] aligned;
    logic [XLEN-1:0] kept;

    // Place the write data in its lane.
    assign aligned = hi_lane ? (wr_data << BYTE_W) : wr_data;

    // Bits outside the lane: old value, or zero for the clearing width.
    assign kept = clear_upper ? '0 : (old_val & ~lane_mask);

    // Combine the kept bits with the new lane contents.
    assign new_val = kept | (aligned & lane_mask);

endmodule

// File: rtl/gpr_read_port.sv
// Module gpr_read_port
// One combinational read port: it selects a register, masks the lane
// and right-aligns it. Illegal requests return zero because their mask
// is empty. Assumes the register array is packed, entry 0 at the bottom.
module gpr_read_port #(
    parameter int XLEN           = 64,
    parameter int NREGS          = 16,
    parameter int HI_ALIAS_NREGS = 4,
    parameter int IDX_W          = $clog2(NREGS)
) (
    input  logic [NREGS-1:0][XLEN-1:0] regs_i,
    input  logic [IDX_W-1:0]           idx,
    input  logic [2:0]                 size,
    output logic [XLEN-1:0]            data,
    output logic                       illegal
);
    localparam int BYTE_W = 8;

    logic            legal;
    logic [XLEN-1:0] lane_mask;
    logic            clear_upper_unused;
    logic            hi_lane;
    logic [XLEN-1:0] selected;
    logic [XLEN-1:0] masked;

    gpr_access_decode #(
        .XLEN(XLEN), .NREGS(NREGS),
        .HI_ALIAS_NREGS(HI_ALIAS_NREGS), .IDX_W(IDX_W)
    ) u_dec (
        .idx(idx), .size(size), .legal(legal), .lane_mask(lane_mask),
        .clear_upper(clear_upper_unused), .hi_lane(hi_lane)
    );

    // Pick the addressed register.
    assign selected = regs_i[idx];

    // Keep only the lane of the access.
    assign masked = selected & lane_mask;

    // Right-align the second-byte lane; other lanes already start at bit 0.
    assign data = hi_lane ? (masked >> BYTE_W) : masked;

    // Report illegal requests.
    assign illegal = ~legal;

    // clear_upper matters only to writes.
    logic unused_ok;
    assign unused_ok = clear_upper_unused;

endmodule

// File: rtl/gpr_file.sv
// Module gpr_file
// Sixteen 64-bit general registers with width-selective writes and two
// zero-extending combinational read ports. Writes land at the rising
// edge. Reset is synchronous and active low. Reads see the pre-write
// value in the cycle of a write.
module gpr_file #(
    parameter int NREGS          = 16,
    parameter int XLEN           = 64,
    parameter int HI_ALIAS_NREGS = 4,
    parameter int IDX_W          = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [2:0]       wr_size,
    input  logic [XLEN-1:0]  wr_data,
    output logic             wr_illegal,
    input  logic [IDX_W-1:0] rda_idx,
    input  logic [2:0]       rda_size,
    output logic [XLEN-1:0]  rda_data,
    output logic             rda_illegal,
    input  logic [IDX_W-1:0] rdb_idx,
    input  logic [2:0]       rdb_size,
    output logic [XLEN-1:0]  rdb_data,
    output logic             rdb_illegal
);
    logic [NREGS-1:0][XLEN-1:0] regs_q;

    logic            wr_legal;
    logic [XLEN-1:0] wr_lane;
    logic            wr_clear_upper;
    logic            wr_hi_lane;
    logic [XLEN-1:0] wr_old;
    logic [XLEN-1:0] wr_new;
    logic            wr_commit;

    gpr_access_decode #(
        .XLEN(XLEN), .NREGS(NREGS),
        .HI_ALIAS_NREGS(HI_ALIAS_NREGS), .IDX_W(IDX_W)
    ) u_wr_dec (
        .idx(wr_idx), .size(wr_size), .legal(wr_legal), .lane_mask(wr_lane),
        .clear_upper(wr_clear_upper), .hi_lane(wr_hi_lane)
    );

    // Current contents of the register being written.
    assign wr_old = regs_q[wr_idx];

    gpr_write_merge #(.XLEN(XLEN)) u_merge (
        .old_val(wr_old), .wr_data(wr_data), .lane_mask(wr_lane),
        .clear_upper(wr_clear_upper), .hi_lane(wr_hi_lane), .new_val(wr_new)
    );

    // A write goes ahead only when enabled and legal.
    assign wr_commit  = wr_en & wr_legal;
    assign wr_illegal = wr_en & ~wr_legal;

    // One storage register per index, each with its own write select.
    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [XLEN-1:0] q;
        logic            sel;

        // Index match for this entry.
        assign sel = wr_commit && (wr_idx == IDX_W'(g));

        // Reset clears the entry; a selected write loads the merged value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (sel) begin
                q <= wr_new;
            end
        end

        assign regs_q[g] = q;
    end

    gpr_read_port #(
        .XLEN(XLEN), .NREGS(NREGS),
        .HI_ALIAS_NREGS(HI_ALIAS_NREGS), .IDX_W(IDX_W)
    ) u_rd_a (
        .regs_i(regs_q), .idx(rda_idx), .size(rda_size),
        .data(rda_data), .illegal(rda_illegal)
    );

    gpr_read_port #(
        .XLEN(XLEN), .NREGS(NREGS),
        .HI_ALIAS_NREGS(HI_ALIAS_NREGS), .IDX_W(IDX_W)
    ) u_rd_b (
        .regs_i(regs_q), .idx(rdb_idx), .size(rdb_size),
        .data(rdb_data), .illegal(rdb_illegal)
    );

endmodule

// File: rtl/gpr_file_chk.sv
// Module gpr_file_chk
// Temporal checks on the register file, bound to gpr_file.
// It observes the storage array and the write port.
module gpr_file_chk #(
    parameter int NREGS          = 16,
    parameter int XLEN           = 64,
    parameter int HI_ALIAS_NREGS = 4,
    parameter int IDX_W          = $clog2(NREGS)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [IDX_W-1:0]           wr_idx,
    input logic [2:0]                 wr_size,
    input logic                       wr_illegal,
    input logic [NREGS-1:0][XLEN-1:0] regs_q
);
    localparam int HALF_W = 16;
    localparam int WORD_W = 32;
    localparam logic [IDX_W:0] HI_LIMIT = HI_ALIAS_NREGS[IDX_W:0];

    // R1: the first active cycle after reset sees an all-zero file.
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (regs_q == '0));

    // R3: a word write leaves the upper half zero.
    a_r3_word_clears_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 3'd3) |=> (regs_q[$past(wr_idx)][XLEN-1:WORD_W] == '0));

    // R4: a half write keeps bits above 15.
    a_r4_half_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 3'd2) |=>
        (regs_q[$past(wr_idx)][XLEN-1:HALF_W] == $past(regs_q[wr_idx][XLEN-1:HALF_W])));

    // R7: second-byte alias beyond the first entries raises the flag.
    a_r7_hi_alias_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 3'd1 && ({1'b0, wr_idx} >= HI_LIMIT)) |-> wr_illegal);

    // R7: an illegal write changes nothing.
    a_r7_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_illegal |=> $stable(regs_q));

    // R8: undefined width codes are flagged.
    a_r8_bad_size_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size > 3'd4) |-> wr_illegal);

    // R10: a disabled port neither writes nor flags.
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));

    a_r10_idle_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !wr_illegal);

endmodule

bind gpr_file gpr_file_chk #(
    .NREGS(NREGS), .XLEN(XLEN),
    .HI_ALIAS_NREGS(HI_ALIAS_NREGS), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_size(wr_size), .wr_illegal(wr_illegal), .regs_q(regs_q)
);

// File: tb/gpr_file_bench.sv
module gpr_file_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [2:0]  wr_size;
    logic [63:0] wr_data;
    logic        wr_illegal;
    logic [3:0]  rda_idx, rdb_idx;
    logic [2:0]  rda_size, rdb_size;
    logic [63:0] rda_data, rdb_data;
    logic        rda_illegal, rdb_illegal;

    int checks = 0;
    int errors = 0;
    logic [63:0] mdl [16];

    always #10 clk = ~clk;

    gpr_file u_gpr_file (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_size(wr_size), .wr_data(wr_data), .wr_illegal(wr_illegal),
        .rda_idx(rda_idx), .rda_size(rda_size), .rda_data(rda_data),
        .rda_illegal(rda_illegal), .rdb_idx(rdb_idx), .rdb_size(rdb_size),
        .rdb_data(rdb_data), .rdb_illegal(rdb_illegal)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic exp_ill(input int idx, input int s);
        return (s == 1 && idx >= 4) || (s > 4);
    endfunction

    function automatic logic [63:0] exp_merge(input logic [63:0] p, input logic [63:0] d,
                                              input int idx, input int s);
        case (s)
            0: return (p & ~64'hFF) | {56'd0, d[7:0]};
            1: return (idx < 4) ? ((p & ~64'hFF00) | {48'd0, d[7:0], 8'd0}) : p;
            2: return (p & ~64'hFFFF) | {48'd0, d[15:0]};
            3: return {32'd0, d[31:0]};
            4: return d;
            default: return p;
        endcase
    endfunction

    function automatic logic [63:0] exp_read(input logic [63:0] v, input int idx, input int s);
        case (s)
            0: return {56'd0, v[7:0]};
            1: return (idx < 4) ? {56'd0, v[15:8]} : 64'd0;
            2: return {48'd0, v[15:0]};
            3: return {32'd0, v[31:0]};
            4: return v;
            default: return 64'd0;
        endcase
    endfunction

    function automatic string req_of(input int idx, input int s);
        case (s)
            0: return "R5";
            1: return (idx < 4) ? "R6" : "R7";
            2: return "R4";
            3: return "R3";
            4: return "R2";
            default: return "R8";
        endcase
    endfunction

    // One write; port A checks the read-before-write value (R9).
    task automatic do_write(input int idx, input int s, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_size = 3'(s); wr_data = d;
        rda_idx = 4'(idx); rda_size = 3'd4;
        #1;
        chk("R9 same-cycle read", rda_data, mdl[idx]);
        chk({req_of(idx, s), " wr_illegal"}, {63'd0, wr_illegal}, {63'd0, exp_ill(idx, s)});
        @(posedge clk);
        mdl[idx] = exp_merge(mdl[idx], d, idx, s);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 16; i++) begin
            rda_idx = 4'(i); rda_size = 3'd4;
            #1;
            chk(req, rda_data, mdl[i]);
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_size = '0; wr_data = '0;
        rda_idx = '0; rda_size = 3'd4; rdb_idx = '0; rdb_size = 3'd4;
        for (int i = 0; i < 16; i++) mdl[i] = 64'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 after reset");

        // Sweep every index against every width code.
        for (int idx = 0; idx < 16; idx++) begin
            for (int s = 0; s < 8; s++) begin
                logic [63:0] p, d;
                p = 64'hF0E1_D2C3_B4A5_9687 ^ (64'h0101_0101_0101_0101 * idx);
                d = 64'h8899_AABB_CCDD_EEFF + (64'h1357_9BDF_2468_ACE1 * (s + 1));
                do_write(idx, 4, p);
                do_write(idx, s, d);
                rda_idx = 4'(idx); rda_size = 3'd4;
                rdb_idx = 4'(idx); rdb_size = 3'(s);
                #1;
                chk({req_of(idx, s), " full value"}, rda_data, mdl[idx]);
                chk({req_of(idx, s), " R9 slice read"}, rdb_data, exp_read(mdl[idx], idx, s));
                chk({req_of(idx, s), " read flag"}, {63'd0, rdb_illegal}, {63'd0, exp_ill(idx, s)});
            end
        end

        // R10: disabled port carrying a legal and then an illegal request.
        @(negedge clk);
        wr_en = 1'b0; wr_idx = 4'd2; wr_size = 3'd4; wr_data = 64'hDEAD_BEEF_DEAD_BEEF;
        @(negedge clk);
        wr_idx = 4'd9; wr_size = 3'd1;
        #1;
        chk("R10 no flag when disabled", {63'd0, wr_illegal}, 64'd0);
        @(negedge clk);
        check_all("R10 file unchanged");

        // Final sweep: no write reached the wrong index.
        check_all("R2 final model compare");

        // Reset in the middle of the run.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) mdl[i] = 64'd0;
        check_all("R1 mid-run reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule